// File: doc/BRIEF.md
# Cascaded Event Interrupt Controller

This block gathers single-cycle event pulses from up to 96 hardware sources and holds them in three 32-bit pending words. Each event is named by a 7-bit number. The upper two bits of that number pick the word and the lower five bits pick the bit inside it. Three interrupt levels each keep their own mask for every pending word. A level's output is raised while any pending bit in any word meets a set bit of that level's mask.

Word 0 gives up its two top bits to summary flags. Bit 30 reports that word 1 holds something, and bit 31 reports the same for word 2. Software cannot clear these flags. They drop only when the word they summarise is emptied by a clear. Word 1 cannot be cleared from the bus, so only hardware clears empty it. Words 0 and 2 use write-one-to-clear on the register bus. The mask registers are plain read/write registers.

Top module: `casc_evt_intc`

## Requirements
- R1: A set strobe with event number N sets bit N[4:0] of pending word N[6:5] at the next clock edge. Event numbers 96 to 127 (word index 3) change nothing.
- R2: Setting any event in word 1 sets word 0 bit 30, and setting any event in word 2 sets word 0 bit 31, in the same cycle as the event bit. At all times word 0 bit 30 equals "word 1 nonzero" and bit 31 equals "word 2 nonzero".
- R3: A bus write to address 0 (pending word 0) clears every word-0 bit that is 1 in the write data, except bits 31 and 30, which keep their value.
- R4: A bus write to address 1 (pending word 1) changes no state.
- R5: A bus write to address 2 clears the word-2 bits that are 1 in the write data. If the word is then empty, word 0 bit 31 clears in the same cycle.
- R6: A clear strobe with event number N clears that single bit. If this empties word 1 or word 2, word 0 bit 30 or bit 31 respectively clears in the same cycle.
- R7: Set or clear strobes naming event 30 or 31 have no effect.
- R8: When a set names a bit in the same cycle that a clear strobe or a bus clear removes it, the bit ends up set.
- R9: Mask registers sit at address 4*(L+1)+W for level L (0..2) and word W (0..2), and they read back what was written. irq_o[L] becomes 1 at the clock edge after a cycle in which some pending word ANDed with its level-L mask is nonzero, and 0 one edge after that AND becomes zero. irq_o[0] is the highest priority.
- R10: Reset clears all pending bits, summary bits, masks and interrupt outputs. Reads of an address whose low two bits are 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_vld | input | 1 | Set strobe |
| evt_set_num | input | 7 | Event number to set |
| evt_clr_vld | input | 1 | Clear strobe |
| evt_clr_num | input | 7 | Event number to clear |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address (also selects the read data) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_o | output | 3 | Level interrupt outputs, bit 0 highest priority |

## Verification
On every cycle the assertions check several properties. The summary flags must match the emptiness of words 1 and 2. A bus write to word 1, or to word 0, must leave the read-only word or the summary flags untouched. A valid set must land even when a clear strikes the same bit. Out-of-range event numbers must change nothing. The interrupts must fall silent once nothing is pending. Other behaviour can only be shown by the bench scenarios, which compare against a reference model. These cover the exact one-cycle interrupt latency, mask read-back and the per-level routing of masked bits. They also cover the collapse of a summary flag when a bus clear or a hardware clear empties a word, and the ignored reserved event codes.

// File: rtl/casc_evt_pkg.sv
package casc_evt_pkg;

   // How a pending word reacts to a bus write aimed at it
   typedef enum logic [1:0] {
      BCLR_NONE = 2'd0,   // bus writes ignored
      BCLR_PROT = 2'd1,   // write-one-to-clear except protected bits
      BCLR_FULL = 2'd2    // write-one-to-clear on every bit
   } bclr_mode_e;

   function automatic bclr_mode_e word_mode(input int w, input int ro_word);
      if (w == 0)
         return BCLR_PROT;
      else if (w == ro_word)
         return BCLR_NONE;
      else
         return BCLR_FULL;
   endfunction

endpackage

// File: rtl/casc_evt_word.sv
module casc_evt_word
   import casc_evt_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter int          BIT_W     = 5,
   parameter bclr_mode_e  BCLR_MODE = BCLR_FULL,
   parameter logic [WORD_W-1:0] PROT_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_hit,
   input  logic [BIT_W-1:0]  set_bit,
   input  logic              clr_hit,
   input  logic [BIT_W-1:0]  clr_bit,
   input  logic              bus_clr_en,
   input  logic [WORD_W-1:0] bus_clr_data,
   input  logic [WORD_W-1:0] sum_set,
   input  logic [WORD_W-1:0] sum_clr,
   output logic [WORD_W-1:0] pend_q,
   output logic              drained
);

   localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

   logic [WORD_W-1:0] set_vec;
   logic [WORD_W-1:0] clr_vec;
   logic [WORD_W-1:0] bus_vec;
   logic              bus_act;
   logic [WORD_W-1:0] pend_d;

   always_comb begin
      set_vec = set_hit ? ((ONE << set_bit) & ~PROT_MASK) : '0;
      clr_vec = clr_hit ? ((ONE << clr_bit) & ~PROT_MASK) : '0;
   end

   generate
      if (BCLR_MODE == BCLR_NONE) begin : g_bus_ro
         assign bus_vec = '0;
         assign bus_act = 1'b0;
      end else if (BCLR_MODE == BCLR_PROT) begin : g_bus_prot
         assign bus_vec = bus_clr_en ? (bus_clr_data & ~PROT_MASK) : '0;
         assign bus_act = bus_clr_en;
      end else begin : g_bus_full
         assign bus_vec = bus_clr_en ? bus_clr_data : '0;
         assign bus_act = bus_clr_en;
      end
   endgenerate

   // Set sources are OR-ed last so they win over every clear source
   always_comb begin
      pend_d  = (pend_q & ~clr_vec & ~bus_vec & ~sum_clr) | set_vec | sum_set;
      drained = (clr_hit | bus_act) & (pend_d == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= pend_d;
   end

endmodule

// File: rtl/casc_evt_lvl.sv
module casc_evt_lvl #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WORDS-1:0]          wr_en,
   input  logic [WORD_W-1:0]             wdata,
   input  logic [NUM_WORDS*WORD_W-1:0]   pend_flat,
   output logic [NUM_WORDS*WORD_W-1:0]   mask_flat,
   output logic                          irq_q
);

   logic [NUM_WORDS-1:0] word_hit;

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_flat[w*WORD_W +: WORD_W] <= '0;
            else if (wr_en[w])
               mask_flat[w*WORD_W +: WORD_W] <= wdata;
         end
         assign word_hit[w] = |(pend_flat[w*WORD_W +: WORD_W] &
                                mask_flat[w*WORD_W +: WORD_W]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= |word_hit;
   end

endmodule

// File: rtl/casc_evt_regbus.sv
module casc_evt_regbus #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 3,
   parameter int NUM_LVL   = 3,
   parameter int ADDR_W    = 4
) (
   input  logic                                bus_wr,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic [NUM_WORDS*WORD_W-1:0]         pend_flat,
   input  logic [NUM_LVL*NUM_WORDS*WORD_W-1:0] mask_flat,
   output logic [NUM_WORDS-1:0]                pend_clr_en,
   output logic [NUM_LVL*NUM_WORDS-1:0]        mask_wr_en,
   output logic [WORD_W-1:0]                   bus_rdata
);

   localparam int RGN_W = ADDR_W - 2;

   logic [RGN_W-1:0] region;
   logic [1:0]       slot;
   logic             slot_ok;

   assign region  = bus_addr[ADDR_W-1:2];
   assign slot    = bus_addr[1:0];
   assign slot_ok = int'(slot) < NUM_WORDS;

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pdec
         assign pend_clr_en[w] = bus_wr && (region == '0) && (int'(slot) == w);
      end
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_ldec
         for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wdec
            assign mask_wr_en[l*NUM_WORDS+w] =
               bus_wr && (int'(region) == l + 1) && (int'(slot) == w);
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (slot_ok) begin
         if (region == '0)
            bus_rdata = pend_flat[int'(slot)*WORD_W +: WORD_W];
         else if (int'(region) <= NUM_LVL)
            bus_rdata = mask_flat[((int'(region)-1)*NUM_WORDS + int'(slot))*WORD_W +: WORD_W];
      end
   end

endmodule

// File: rtl/casc_evt_intc.sv
module casc_evt_intc
   import casc_evt_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 3,
   parameter int NUM_LVL   = 3,
   parameter int EVT_W     = 7,
   parameter int ADDR_W    = 4,
   parameter int RO_WORD   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_set_vld,
   input  logic [EVT_W-1:0]  evt_set_num,
   input  logic              evt_clr_vld,
   input  logic [EVT_W-1:0]  evt_clr_num,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic [NUM_LVL-1:0] irq_o
);

   localparam int BIT_W  = $clog2(WORD_W);
   localparam int WSEL_W = EVT_W - BIT_W;
   localparam int SUM_LO = WORD_W - NUM_WORDS + 1;
   localparam logic [WORD_W-1:0] SUM_MASK =
      {{(NUM_WORDS-1){1'b1}}, {SUM_LO{1'b0}}};

   // Elaboration-time configuration checks
   generate
      if (WORD_W != (1 << BIT_W)) begin : g_bad_word
         $error("WORD_W must be a power of two");
      end
      if (NUM_WORDS < 2 || NUM_WORDS > 4) begin : g_bad_words
         $error("NUM_WORDS must be 2..4");
      end
      if (NUM_WORDS > (1 << WSEL_W)) begin : g_bad_evt
         $error("EVT_W too narrow for NUM_WORDS");
      end
      if (NUM_LVL + 1 > (1 << (ADDR_W - 2))) begin : g_bad_addr
         $error("ADDR_W too narrow for NUM_LVL");
      end
      if (RO_WORD < 1 || RO_WORD >= NUM_WORDS) begin : g_bad_ro
         $error("RO_WORD must name a word other than 0");
      end
   endgenerate

   logic [NUM_WORDS-1:0]                set_hit;
   logic [NUM_WORDS-1:0]                clr_hit;
   logic [NUM_WORDS-1:0]                drained;
   logic [NUM_WORDS-1:0]                pend_clr_en;
   logic [NUM_LVL*NUM_WORDS-1:0]        mask_wr_en;
   logic [NUM_WORDS*WORD_W-1:0]         pend_flat;
   logic [NUM_LVL*NUM_WORDS*WORD_W-1:0] mask_flat;
   logic [WORD_W-1:0]                   sum_set;
   logic [WORD_W-1:0]                   sum_clr;

   // Summary flags in word 0: set with any event of their word,
   // dropped when a clear leaves that word empty
   always_comb begin
      sum_set = '0;
      sum_clr = '0;
      for (int k = 1; k < NUM_WORDS; k++) begin
         sum_set[SUM_LO+k-1] = set_hit[k];
         sum_clr[SUM_LO+k-1] = drained[k];
      end
   end

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         localparam bclr_mode_e MODE = word_mode(w, RO_WORD);
         localparam logic [WORD_W-1:0] PROT = (w == 0) ? SUM_MASK : '0;

         assign set_hit[w] = evt_set_vld &&
                             (evt_set_num[EVT_W-1:BIT_W] == WSEL_W'(w));
         assign clr_hit[w] = evt_clr_vld &&
                             (evt_clr_num[EVT_W-1:BIT_W] == WSEL_W'(w));

         casc_evt_word #(
            .WORD_W    (WORD_W),
            .BIT_W     (BIT_W),
            .BCLR_MODE (MODE),
            .PROT_MASK (PROT)
         ) word_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .set_hit      (set_hit[w]),
            .set_bit      (evt_set_num[BIT_W-1:0]),
            .clr_hit      (clr_hit[w]),
            .clr_bit      (evt_clr_num[BIT_W-1:0]),
            .bus_clr_en   (pend_clr_en[w]),
            .bus_clr_data (bus_wdata),
            .sum_set      ((w == 0) ? sum_set : '0),
            .sum_clr      ((w == 0) ? sum_clr : '0),
            .pend_q       (pend_flat[w*WORD_W +: WORD_W]),
            .drained      (drained[w])
         );
      end

      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         casc_evt_lvl #(
            .WORD_W    (WORD_W),
            .NUM_WORDS (NUM_WORDS)
         ) lvl_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (mask_wr_en[l*NUM_WORDS +: NUM_WORDS]),
            .wdata     (bus_wdata),
            .pend_flat (pend_flat),
            .mask_flat (mask_flat[l*NUM_WORDS*WORD_W +: NUM_WORDS*WORD_W]),
            .irq_q     (irq_o[l])
         );
      end
   endgenerate

   casc_evt_regbus #(
      .WORD_W    (WORD_W),
      .NUM_WORDS (NUM_WORDS),
      .NUM_LVL   (NUM_LVL),
      .ADDR_W    (ADDR_W)
   ) regbus_i (
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .pend_flat   (pend_flat),
      .mask_flat   (mask_flat),
      .pend_clr_en (pend_clr_en),
      .mask_wr_en  (mask_wr_en),
      .bus_rdata   (bus_rdata)
   );

endmodule

// File: rtl/casc_evt_intc_chk.sv
module casc_evt_intc_chk #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 3,
   parameter int NUM_LVL   = 3,
   parameter int EVT_W     = 7,
   parameter int ADDR_W    = 4,
   parameter int RO_WORD   = 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        evt_set_vld,
   input logic [EVT_W-1:0]            evt_set_num,
   input logic                        evt_clr_vld,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [NUM_LVL-1:0]          irq_o,
   input logic [NUM_WORDS*WORD_W-1:0] pend_all
);

   localparam int SUM_LO = WORD_W - NUM_WORDS + 1;
   localparam int TOTAL  = NUM_WORDS * WORD_W;

   logic set_usable;
   assign set_usable = evt_set_vld && (int'(evt_set_num) < TOTAL) &&
                       !(int'(evt_set_num) >= SUM_LO && int'(evt_set_num) < WORD_W);

   generate
      for (genvar k = 1; k < NUM_WORDS; k++) begin : g_sum
         // R2
         casc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend_all[SUM_LO+k-1] == (pend_all[k*WORD_W +: WORD_W] != '0));
      end
   endgenerate

   // R4
   ro_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && int'(bus_addr) == RO_WORD && !evt_set_vld && !evt_clr_vld)
      |=> $stable(pend_all[RO_WORD*WORD_W +: WORD_W]));

   // R3
   flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && !evt_set_vld && !evt_clr_vld)
      |=> $stable(pend_all[WORD_W-1:SUM_LO]));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_usable |=> pend_all[$past(evt_set_num)]);

   // R1
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set_vld && int'(evt_set_num) >= TOTAL && !evt_clr_vld && !bus_wr)
      |=> $stable(pend_all));

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_all == '0) |=> (irq_o == '0));

endmodule

bind casc_evt_intc casc_evt_intc_chk #(
   .WORD_W    (WORD_W),
   .NUM_WORDS (NUM_WORDS),
   .NUM_LVL   (NUM_LVL),
   .EVT_W     (EVT_W),
   .ADDR_W    (ADDR_W),
   .RO_WORD   (RO_WORD)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_set_vld (evt_set_vld),
   .evt_set_num (evt_set_num),
   .evt_clr_vld (evt_clr_vld),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .irq_o       (irq_o),
   .pend_all    (pend_flat)
);

// File: tb/casc_evt_intc_tb_top.sv
`timescale 1ns/1ps
module casc_evt_intc_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_set_vld = 1'b0;
   logic [6:0]  evt_set_num = '0;
   logic        evt_clr_vld = 1'b0;
   logic [6:0]  evt_clr_num = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq_o;

   always #2.5 clk = ~clk;

   casc_evt_intc dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_set_vld (evt_set_vld),
      .evt_set_num (evt_set_num),
      .evt_clr_vld (evt_clr_vld),
      .evt_clr_num (evt_clr_num),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .irq_o       (irq_o)
   );

   typedef struct {
      logic [31:0] rd;
      logic [2:0]  irq;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_checks = 0;
   int          n_fails  = 0;
   logic [31:0] m_pend [3];
   logic [31:0] m_mask [3][3];

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [3:0] a);
      if (a[1:0] == 2'd3) return '0;
      if (a[3:2] == 2'd0) return m_pend[a[1:0]];
      return m_mask[a[3:2]-1][a[1:0]];
   endfunction

   function automatic bit usable(input logic [6:0] n);
      return (n[6:5] != 2'd3) && !(n[6:5] == 2'd0 && n[4:0] >= 5'd30);
   endfunction

   // Driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input bit sv, input logic [6:0] sn,
                       input bit cv, input logic [6:0] cn,
                       input bit bw, input logic [3:0] ba,
                       input logic [31:0] bd, input string tag);
      exp_t        e;
      logic [31:0] np [3];
      @(negedge clk);
      evt_set_vld = sv; evt_set_num = sn;
      evt_clr_vld = cv; evt_clr_num = cn;
      bus_wr = bw; bus_addr = ba; bus_wdata = bd;
      for (int l = 0; l < 3; l++) begin
         e.irq[l] = |((m_pend[0] & m_mask[l][0]) | (m_pend[1] & m_mask[l][1]) |
                      (m_pend[2] & m_mask[l][2]));
      end
      for (int w = 0; w < 3; w++) np[w] = m_pend[w];
      if (bw && ba[3:2] == 2'd0) begin
         if (ba[1:0] == 2'd0) np[0] = np[0] & ~(bd & 32'h3FFF_FFFF);
         else if (ba[1:0] == 2'd2) np[2] = np[2] & ~bd;
      end
      if (cv && usable(cn)) np[cn[6:5]][cn[4:0]] = 1'b0;
      if (sv && usable(sn)) np[sn[6:5]][sn[4:0]] = 1'b1;
      np[0][30] = |np[1];
      np[0][31] = |np[2];
      if (bw && ba[3:2] != 2'd0 && ba[1:0] != 2'd3)
         m_mask[ba[3:2]-1][ba[1:0]] = bd;
      for (int w = 0; w < 3; w++) m_pend[w] = np[w];
      e.rd  = model_read(ba);
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic idle(input logic [3:0] ba, input string tag);
      step(0, '0, 0, '0, 0, ba, '0, tag);
   endtask

   // Monitor: compares the design after each edge with the queued item
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(bus_rdata, e.rd, e.tag);
            check({29'd0, irq_o}, {29'd0, e.irq}, "R9 irq");
         end
      end
   end

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      for (int w = 0; w < 3; w++) begin
         m_pend[w] = '0;
         for (int l = 0; l < 3; l++) m_mask[l][w] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state and unmapped reads
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         bus_addr = 4'(a);
         #1;
         check(bus_rdata, 32'd0, "R10 reset read");
      end
      check({29'd0, irq_o}, 32'd0, "R10 irq reset");

      // R9 masks: level0 word0 bit5, level1 word1, level2 word2
      step(0, '0, 0, '0, 1, 4'd4, 32'h0000_0020, "R9 mask write");
      step(0, '0, 0, '0, 1, 4'd9, 32'hFFFF_FFFF, "R9 mask write");
      step(0, '0, 0, '0, 1, 4'd14, 32'h0000_00C0, "R9 mask write");
      step(0, '0, 0, '0, 1, 4'd7, 32'hDEAD_BEEF, "R10 unmapped write");
      idle(4'd4, "R9 mask readback");

      // R1 basic set into word 0
      step(1, 7'd5, 0, '0, 0, 4'd0, '0, "R1 set word0");
      idle(4'd0, "R9 irq level0 rise");
      // R2 summary flags
      step(1, 7'd40, 0, '0, 0, 4'd0, '0, "R2 flag30 set");
      idle(4'd1, "R1 word1 bit8");
      step(1, 7'd70, 0, '0, 0, 4'd0, '0, "R2 flag31 set");
      idle(4'd2, "R1 word2 bit6");
      // R1 out-of-range event
      step(1, 7'd100, 0, '0, 0, 4'd2, '0, "R1 event 100 ignored");
      // R7 reserved codes
      step(1, 7'd30, 0, '0, 0, 4'd0, '0, "R7 set 30 ignored");
      step(0, '0, 1, 7'd31, 0, 4'd0, '0, "R7 clear 31 ignored");
      // R3 bus clear of word 0 keeps flags
      step(0, '0, 0, '0, 1, 4'd0, 32'hFFFF_FFFF, "R3 flags kept");
      // R4 word1 read-only
      step(0, '0, 0, '0, 1, 4'd1, 32'hFFFF_FFFF, "R4 word1 write ignored");
      idle(4'd0, "R4 flag30 still set");
      // R6 hardware clear empties word 1
      step(0, '0, 1, 7'd40, 0, 4'd0, '0, "R6 flag30 cleared");
      // R5 bus clear of word 2
      step(1, 7'd71, 0, '0, 0, 4'd2, '0, "R5 word2 two bits");
      step(0, '0, 0, '0, 1, 4'd2, 32'h0000_0040, "R5 partial clear");
      idle(4'd0, "R5 flag31 kept");
      step(0, '0, 0, '0, 1, 4'd2, 32'h0000_0080, "R5 word2 emptied");
      idle(4'd0, "R5 flag31 cleared");
      // R8 set wins
      step(1, 7'd50, 1, 7'd50, 0, 4'd1, '0, "R8 set vs hw clear");
      step(1, 7'd65, 0, '0, 1, 4'd2, 32'h0000_0002, "R8 set vs bus clear");
      idle(4'd0, "R8 flags both set");
      // R6 hardware clear of word 2 last bit
      step(0, '0, 1, 7'd65, 0, 4'd0, '0, "R6 flag31 cleared");
      step(0, '0, 1, 7'd50, 0, 4'd0, '0, "R6 flag30 cleared again");
      idle(4'd0, "R9 irq fall");

      // Random traffic
      for (int i = 0; i < 3000; i++) begin
         int          kind;
         logic [6:0]  sn;
         logic [6:0]  cn;
         logic [3:0]  ba;
         logic [31:0] bd;
         kind = $urandom_range(0, 5);
         sn = 7'($urandom_range(0, 127));
         cn = 7'($urandom_range(0, 127));
         ba = 4'($urandom_range(0, 15));
         bd = $urandom() & $urandom();
         case (kind)
            0, 1: step(1, sn, 0, '0, 0, {2'd0, sn[6:5]}, '0, "R1 random set");
            2:    step(0, '0, 1, cn, 0, {2'd0, cn[6:5]}, '0, "R6 random clear");
            3:    step(1, sn, 1, cn, 0, 4'd0, '0, "R8 random set+clear");
            4:    step(0, '0, 0, '0, 1, {2'd0, ba[1:0]}, bd, "R5 random bus clear");
            default: step($urandom_range(0, 1) == 1, sn, 0, '0, 1, ba, bd, "R9 random bus");
         endcase
      end
      idle(4'd0, "R2 final");
      @(negedge clk);
      evt_set_vld = 1'b0; evt_clr_vld = 1'b0; bus_wr = 1'b0;
      while (sb_q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule